// File: doc/BRIEF.md
# Real-Time Counter with Coherent Shadow Buffer

This block keeps a running calendar clock made of eight BCD byte fields and puts one shadow buffer between those live counters and a byte-level serial transaction engine. When a transaction reaches the acknowledge that comes before its first data byte, the live time is copied into the buffer. A read then returns bytes only from that frozen copy. A write edits the copy byte by byte. The live counters never pause.

A write reaches the live counters only when a stop closes an open write session that accepted at least one byte. The commit is atomic and forces the sub-second field to zero, which also restarts the 1 Hz output phase. An abort, a new start, or a stop that arrives before any byte has been written discards the edits. Sub-second steps come from an external prescaler pulse at 100 Hz.

Write bytes enter through a valid/ready port. `wr_ready` is high only while a write session is open, so a byte that arrives outside a session waits and is never taken. A byte transfers on any cycle where `wr_valid` and `wr_ready` are both high. The transaction strobes and the read index are plain single-cycle controls.

Top module: `rtc_snapshot_unit`

## Requirements
- R1: After reset, the time fields are all 00 except date and month, which are 01. `wr_ready` is low and `pps_out` is high.
- R2: Byte index map: 0 sub-second (00-99), 1 second, 2 minute, 3 hour (00-23), 4 weekday (00-06), 5 date, 6 month (01-12), 7 year (00-99). Every field is two-digit BCD. Each `tick` raises the sub-second field by one, and carries ripple upward in the order sub-second, second, minute, hour, then weekday and date, then month, then year.
- R3: The date wraps to 01 after the last day of its month. Months 04, 06, 09 and 11 have 30 days and month 02 has 28 days. Month 02 has 29 days when the year value is divisible by 4. All other months have 31 days.
- R4: The cycle after `ack_pre` (with no `txn_start` or `txn_abort`), the buffer holds the live time from before that edge. `rd_data` shows buffer byte `rd_idx`, and the counters keep running.
- R5: `ack_pre` with `ack_is_write` high opens a write session. `wr_ready` is high only during a write session, and each accepted byte replaces buffer byte `wr_idx`.
- R6: A `stop` during a write session that accepted at least one byte loads buffer bytes 1-7 into the live counters on the following cycle. Bytes that were not written keep the values captured at the snapshot.
- R7: A commit sets the sub-second field to 00 whatever value was written. A tick in the same cycle as the committing stop is dropped.
- R8: `txn_abort`, `txn_start`, or a `stop` with no accepted byte closes the session and leaves the live time unchanged.
- R9: `pps_out` is high exactly while the sub-second field is below 50, so it is high on the cycle after a commit.
- R10: When `ack_pre` and `tick` share a cycle, the snapshot holds the value from before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second step pulse from the prescaler |
| txn_start | input | 1 | Transaction start strobe |
| ack_pre | input | 1 | Acknowledge before the first data byte; takes the snapshot |
| ack_is_write | input | 1 | Qualifies `ack_pre` as a write |
| stop | input | 1 | Transaction stop strobe |
| txn_abort | input | 1 | Invalid-transaction strobe |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be accepted |
| wr_idx | input | 3 | Buffer index of the write byte |
| wr_data | input | 8 | Write byte (BCD) |
| rd_idx | input | 3 | Buffer index for read data |
| rd_data | output | 8 | Buffer byte at `rd_idx` |
| pps_out | output | 1 | 1 Hz square wave |

## Verification
Two pairs of events can land on the same edge. A tick can coincide with the committing stop, and a tick can coincide with the snapshot acknowledge. The bench sets the tick rate to one per cycle during one write and one read so that each collision is certain, and it also lets collisions happen at random elsewhere. A bench model applies the required priorities: the commit wins and the sub-second field reads 00, and the snapshot takes the pre-tick value. The bench checks read-back bytes and `pps_out` against that model every cycle.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NREG = 8;
  localparam int IDXW = $clog2(NREG);
  localparam int IX_SS = 0, IX_SEC = 1, IX_MIN = 2, IX_HR = 3;
  localparam int IX_DOW = 4, IX_DATE = 5, IX_MON = 6, IX_YR = 7;

  typedef logic [NREG-1:0][7:0] rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET =
    {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year/4 test on two BCD digits: even tens need units 0,4,8; odd tens 2,6
  function automatic logic leap_year(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t nxt;
  logic c_ss, c_sec, c_min, c_hr, c_date;
  logic [7:0] mlen;

  always_comb begin
    nxt    = now;
    mlen   = last_day(now[IX_MON], now[IX_YR]);
    c_ss   = (now[IX_SS] == 8'h99);
    c_sec  = c_ss  && (now[IX_SEC] == 8'h59);
    c_min  = c_sec && (now[IX_MIN] == 8'h59);
    c_hr   = c_min && (now[IX_HR] == 8'h23);
    c_date = c_hr  && (now[IX_DATE] == mlen);
    nxt[IX_SS] = c_ss ? 8'h00 : bcd_inc(now[IX_SS]);
    if (c_ss)  nxt[IX_SEC] = (now[IX_SEC] == 8'h59) ? 8'h00 : bcd_inc(now[IX_SEC]);
    if (c_sec) nxt[IX_MIN] = (now[IX_MIN] == 8'h59) ? 8'h00 : bcd_inc(now[IX_MIN]);
    if (c_min) nxt[IX_HR]  = (now[IX_HR]  == 8'h23) ? 8'h00 : bcd_inc(now[IX_HR]);
    if (c_hr) begin
      nxt[IX_DOW]  = (now[IX_DOW] == 8'h06) ? 8'h00 : bcd_inc(now[IX_DOW]);
      nxt[IX_DATE] = c_date ? 8'h01 : bcd_inc(now[IX_DATE]);
    end
    if (c_date) begin
      nxt[IX_MON] = (now[IX_MON] == 8'h12) ? 8'h01 : bcd_inc(now[IX_MON]);
      if (now[IX_MON] == 8'h12)
        nxt[IX_YR] = (now[IX_YR] == 8'h99) ? 8'h00 : bcd_inc(now[IX_YR]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    now <= TIME_AT_RESET;
    else if (load) now <= load_val;
    else if (tick) now <= nxt;
  end

  // R2: without a tick or a load the time holds
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(now));
  // R2: seconds move only when the sub-second field wraps
  assert_sec_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && now[IX_SS] != 8'h99) |=> (now[IX_SEC] == $past(now[IX_SEC])));
endmodule

// File: rtl/rtc_shadow_buf.sv
`timescale 1ns/1ps
module rtc_shadow_buf
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            txn_start,
  input  logic            txn_abort,
  input  logic            ack_pre,
  input  logic            ack_is_write,
  input  logic            stop,
  input  logic            wr_valid,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  rtc_time_t       live,
  output logic            wr_ready,
  output logic            commit,
  output rtc_time_t       shadow
);
  logic wr_open, wrote;
  logic kill;

  assign kill     = txn_start || txn_abort;
  assign wr_ready = wr_open;
  assign commit   = stop && wr_open && wrote && !kill && !ack_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      wrote   <= 1'b0;
      shadow  <= TIME_AT_RESET;
    end else if (kill) begin
      wr_open <= 1'b0;
      wrote   <= 1'b0;
    end else if (ack_pre) begin
      shadow  <= live;
      wr_open <= ack_is_write;
      wrote   <= 1'b0;
    end else if (stop) begin
      wr_open <= 1'b0;
    end else if (wr_valid && wr_open) begin
      shadow[wr_idx] <= wr_data;
      wrote          <= 1'b1;
    end
  end

  // R4: the snapshot equals the live time seen before the edge
  assert_snapshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pre && !kill) |=> (shadow == $past(live)));
  // R5: an accepted byte lands at its own index
  assert_byte_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !kill && !ack_pre && !stop)
      |=> (shadow[$past(wr_idx)] == $past(wr_data)));
  // R8: an abort closes the session
  assert_abort_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_abort |=> !wr_ready);
endmodule

// File: rtl/rtc_snapshot_unit.sv
`timescale 1ns/1ps
module rtc_snapshot_unit
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            txn_start,
  input  logic            ack_pre,
  input  logic            ack_is_write,
  input  logic            stop,
  input  logic            txn_abort,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_data,
  output logic            pps_out
);
  localparam logic [7:0] HALF_SEC = 8'h50;

  rtc_time_t live, shadow, load_val;
  logic commit;

  rtc_shadow_buf u_buf (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_abort(txn_abort),
    .ack_pre(ack_pre), .ack_is_write(ack_is_write), .stop(stop),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .live(live),
    .wr_ready(wr_ready), .commit(commit), .shadow(shadow)
  );

  always_comb begin
    load_val        = shadow;
    load_val[IX_SS] = 8'h00;
  end

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(commit),
    .load_val(load_val), .now(live)
  );

  assign rd_data = shadow[rd_idx];
  assign pps_out = (live[IX_SS] < HALF_SEC);

  // R6: a commit copies the edited calendar fields
  assert_commit_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live[NREG-1:1] == $past(shadow[NREG-1:1])));
  // R7: the sub-second field restarts at zero
  assert_commit_ss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live[IX_SS] == 8'h00));
  // R9: the 1 Hz phase restarts high
  assert_pps_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pps_out);
endmodule

// File: tb/test_rtc_snapshot_unit.sv
`timescale 1ns/1ps
module test_rtc_snapshot_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, txs = 0, ack = 0, ackw = 0, stp = 0, abt = 0, wv = 0;
  logic [2:0] widx = 0, rd_idx = 0;
  logic [7:0] wdat = 0, rd_data;
  logic wr_ready, pps_out;

  int total = 0, bad = 0, tick_pct = 0;
  logic [7:0] mt [8];
  logic [7:0] mb [8];
  logic [7:0] rv [8];
  logic [2:0] wi [8];
  logic [7:0] wd [8];
  bit mopen = 0, mwrote = 0;

  rtc_snapshot_unit i_rtc_snapshot_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txn_start(txs), .ack_pre(ack),
    .ack_is_write(ackw), .stop(stp), .txn_abort(abt), .wr_valid(wv),
    .wr_ready(wr_ready), .wr_idx(widx), .wr_data(wdat), .rd_idx(rd_idx),
    .rd_data(rd_data), .pps_out(pps_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic adv_model();
    int ss, se, mi, hr, dw, dt, mo, yr, ml;
    ss = b2i(mt[0]) + 1; se = b2i(mt[1]); mi = b2i(mt[2]); hr = b2i(mt[3]);
    dw = b2i(mt[4]); dt = b2i(mt[5]); mo = b2i(mt[6]); yr = b2i(mt[7]);
    if (mo == 2) ml = (yr % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) ml = 30;
    else ml = 31;
    if (ss == 100) begin
      ss = 0; se++;
      if (se == 60) begin
        se = 0; mi++;
        if (mi == 60) begin
          mi = 0; hr++;
          if (hr == 24) begin
            hr = 0; dw = (dw + 1) % 7; dt++;
            if (dt > ml) begin
              dt = 1; mo++;
              if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
            end
          end
        end
      end
    end
    mt[0] = i2b(ss); mt[1] = i2b(se); mt[2] = i2b(mi); mt[3] = i2b(hr);
    mt[4] = i2b(dw); mt[5] = i2b(dt); mt[6] = i2b(mo); mt[7] = i2b(yr);
  endtask

  // one clock: model follows the required priorities, then pps is checked (R9)
  task automatic cyc();
    logic [7:0] om [8];
    bit cm;
    tick = ($urandom_range(99) < tick_pct);
    @(posedge clk);
    om = mt;
    cm = stp && mopen && mwrote && !txs && !abt && !ack;
    if (cm) begin mt = mb; mt[0] = 8'h00; end
    else if (tick) adv_model();
    if (txs || abt) begin mopen = 0; mwrote = 0; end
    else if (ack) begin mb = om; mopen = ackw; mwrote = 0; end
    else if (stp) mopen = 0;
    else if (wv && mopen) begin mb[widx] = wdat; mwrote = 1; end
    @(negedge clk);
    chk(pps_out == (mt[0] < 8'h50), "R9 pps phase", pps_out, mt[0] < 8'h50);
    txs = 0; ack = 0; ackw = 0; stp = 0; abt = 0; wv = 0;
  endtask

  task automatic do_read(input string req);
    txs = 1; cyc();
    ack = 1; ackw = 0; cyc();
    stp = 1; cyc();
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      rv[i] = rd_data;
      chk(rd_data == mb[i], req, rd_data, mb[i]);
    end
  endtask

  task automatic do_write(input int n, input bit do_abort);
    txs = 1; cyc();
    ack = 1; ackw = 1; cyc();
    for (int i = 0; i < n; i++) begin
      chk(wr_ready == 1'b1, "R5 ready in session", wr_ready, 1);
      wv = 1; widx = wi[i]; wdat = wd[i]; cyc();
    end
    if (do_abort) abt = 1; else stp = 1;
    cyc();
    chk(wr_ready == 1'b0, "R8 session closed", wr_ready, 0);
  endtask

  task automatic set_full(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr);
    for (int i = 0; i < 8; i++) wi[i] = 3'(i);
    wd[0] = 8'h37; wd[1] = s; wd[2] = mi; wd[3] = h;
    wd[4] = dw; wd[5] = dt; wd[6] = mo; wd[7] = yr;
    do_write(8, 0);
  endtask

  function automatic logic [7:0] rand_field(input int idx);
    case (idx)
      0: return i2b($urandom_range(99));
      1, 2: return i2b($urandom_range(59));
      3: return i2b($urandom_range(23));
      4: return i2b($urandom_range(6));
      5: return i2b(1 + $urandom_range(27));
      6: return i2b(1 + $urandom_range(11));
      default: return i2b($urandom_range(99));
    endcase
  endfunction

  bit finished = 0;
  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mt[0] = 8'h00; mt[1] = 8'h00; mt[2] = 8'h00; mt[3] = 8'h00;
    mt[4] = 8'h00; mt[5] = 8'h01; mt[6] = 8'h01; mt[7] = 8'h00;
    mb = mt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(pps_out == 1'b1, "R1 pps after reset", pps_out, 1);
    chk(wr_ready == 1'b0, "R1 ready after reset", wr_ready, 0);
    do_read("R1 reset readback");
    chk(rv[5] == 8'h01 && rv[6] == 8'h01 && rv[7] == 8'h00, "R1 reset date", {rv[7], rv[6], rv[5]}, 24'h000101);

    // R2 R3 year end rollover through every field
    set_full(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h03);
    tick_pct = 100; repeat (100) cyc(); tick_pct = 0;
    do_read("R2 rollover readback");
    chk(rv[7] == 8'h04 && rv[6] == 8'h01 && rv[5] == 8'h01, "R2 year carry", {rv[7], rv[6], rv[5]}, 24'h040101);
    chk(rv[4] == 8'h00 && rv[3] == 8'h00 && rv[1] == 8'h00, "R2 weekday and hour wrap", {rv[4], rv[3], rv[1]}, 0);

    // R3 leap and common February
    set_full(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h04);
    tick_pct = 100; repeat (100) cyc(); tick_pct = 0;
    do_read("R3 leap readback");
    chk(rv[5] == 8'h29 && rv[6] == 8'h02, "R3 leap day", {rv[6], rv[5]}, 16'h0229);
    set_full(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h05);
    tick_pct = 100; repeat (100) cyc(); tick_pct = 0;
    do_read("R3 common year readback");
    chk(rv[5] == 8'h01 && rv[6] == 8'h03, "R3 march first", {rv[6], rv[5]}, 16'h0301);

    // R6 R7 single byte write whose stop collides with a tick
    tick_pct = 100;
    wi[0] = 3'd2; wd[0] = 8'h42; do_write(1, 0);
    tick_pct = 0;
    do_read("R6 single byte commit");
    chk(rv[0] == 8'h00, "R7 ss zero despite tick", rv[0], 0);
    chk(rv[2] == 8'h42, "R6 minute written", rv[2], 8'h42);

    // R8 abort and empty stop
    wi[0] = 3'd2; wd[0] = 8'h17; do_write(1, 1);
    do_read("R8 abort readback");
    chk(rv[2] == 8'h42, "R8 abort keeps minute", rv[2], 8'h42);
    do_write(0, 0);
    do_read("R8 empty stop readback");

    // R10 snapshot while ticking every cycle
    tick_pct = 100;
    do_read("R10 snapshot with tick");
    tick_pct = 0;

    // random mix (R4 R5 R6 R8)
    for (int it = 0; it < 400; it++) begin
      int kind, n;
      tick_pct = 50;
      repeat ($urandom_range(5)) cyc();
      kind = $urandom_range(3);
      if (kind == 0) do_read("R4 random read");
      else begin
        n = (kind == 3) ? 0 : 1 + $urandom_range(2);
        for (int j = 0; j < n; j++) begin
          wi[j] = 3'($urandom_range(7)); wd[j] = rand_field(int'(wi[j]));
        end
        do_write(n, kind == 2);
        do_read("R6 random write readback");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule